// File: doc/BRIEF.md
# Burst Address Expander

This block turns a single burst command into a train of single-transfer address commands. A command arrives on a valid/ready input stream. It carries a start address, a two-bit burst kind, a length field and a size field. For every transfer in the burst the block presents one address on a valid/ready output stream. It holds the input off until the last of those addresses has been taken downstream, so no command is dropped or duplicated. A downstream agent then needs to handle only single-beat accesses.

The three burst kinds are supported. A fixed burst repeats its start address on every beat. An incrementing burst steps the address by the transfer size on each beat. A wrapping burst steps the same way, but its offset folds back to zero once it reaches the length field times the transfer size. Every burst parameter is latched when the command is taken. The block carries no data, IDs or responses. Address, length and size widths are parameters, with a 32-bit address, an 8-bit length field and a 3-bit size field by default.

Top module: `burst_beat_expander`

## Requirements
- R1: A burst taken with length field L produces exactly L+1 output beats, no more and no fewer.
- R2: Kind code 2'b00 (fixed) gives every beat the captured start address. Kind code 2'b11 is treated the same way.
- R3: Kind code 2'b01 (incrementing) gives beat i the address start + i*2^size, truncated to the address width, so a burst that crosses the top of the address space continues from zero.
- R4: Kind code 2'b10 (wrapping) gives beat i the address start + ((i*2^size) mod (L*2^size)). With L = 0 this is a single beat at the start address.
- R5: inReady is high when no burst is in progress, and also in the cycle where the final beat of the current burst is accepted. In every other cycle it is low.
- R6: While outValid is high and outReady is low, outValid stays high and outAddr keeps its value into the next cycle.
- R7: The inputs inAddr, inKind, inLen and inSize have no effect on the beats of a burst after that burst has been captured.
- R8: A synchronous active-high reset leaves outValid low and inReady high on the cycle after it.
- R9: A command presented while a burst drains is captured on the edge that accepts the previous final beat. Its first beat appears on the next cycle, with no idle cycle on the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Burst command valid |
| inReady | output | 1 | Burst command accepted this cycle when inValid is also high |
| inAddr | input | ADDR_W | Start address of the burst |
| inKind | input | 2 | Burst kind: 00 fixed, 01 incrementing, 10 wrapping, 11 treated as fixed |
| inLen | input | LEN_W | Length field; beat count minus one |
| inSize | input | SIZE_W | log2 of the bytes per beat |
| outValid | output | 1 | Beat address valid |
| outReady | input | 1 | Downstream takes the beat this cycle |
| outAddr | output | ADDR_W | Address of the current beat |

## Verification
Two events can fall on the same clock edge: the final beat of one burst leaves, and the next command is captured. The bench provokes this by holding a second command valid while the first one drains. It does so both with the sink always ready and with random sink stalls. The outcome is judged in two ways. First, the beat addresses must match the model for both bursts, in order, with none missing or repeated. Second, with the sink always ready, the beats of both bursts must occupy an unbroken run of cycles whose length equals the total beat count.

// File: rtl/burst_beat_pkg.sv
package burst_beat_pkg;

  typedef enum logic [1:0] {
    KIND_FIXED = 2'b00,
    KIND_INCR  = 2'b01,
    KIND_WRAP  = 2'b10,
    KIND_RSVD  = 2'b11
  } burstKind_e;

  // Strobes from the sequencer to the address datapath
  typedef struct packed {
    logic capture;  // latch a new command, clear the offset
    logic advance;  // step to the next beat of the same burst
  } beatStrobe_t;

endpackage

// File: rtl/burst_beat_ctrl.sv
module burst_beat_ctrl
  import burst_beat_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  output logic             inReady,
  input  logic             outReady,
  output logic             outValid,
  input  logic [LEN_W-1:0] burstLen,
  output beatStrobe_t      strobe
);

  logic             busy;
  logic [LEN_W-1:0] beatCnt;
  logic             isLast;
  logic             outFire;
  logic             finalFire;

  assign isLast    = (beatCnt == burstLen);
  assign outFire   = busy && outReady;
  assign finalFire = outFire && isLast;

  assign inReady        = !busy || finalFire;
  assign outValid       = busy;
  assign strobe.capture = inValid && inReady;
  assign strobe.advance = outFire && !isLast;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      beatCnt <= '0;
    end else begin
      if (strobe.capture) begin
        busy    <= 1'b1;
        beatCnt <= '0;
      end else begin
        if (finalFire) busy <= 1'b0;
        if (strobe.advance) beatCnt <= beatCnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/burst_beat_addr.sv
module burst_beat_addr
  import burst_beat_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 8,
  parameter int SIZE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  beatStrobe_t       strobe,
  input  logic [ADDR_W-1:0] inAddr,
  input  logic [1:0]        inKind,
  input  logic [LEN_W-1:0]  inLen,
  input  logic [SIZE_W-1:0] inSize,
  output logic [LEN_W-1:0]  burstLen,
  output logic [ADDR_W-1:0] outAddr
);

  logic [ADDR_W-1:0] startAddr;
  logic [ADDR_W-1:0] offset;
  logic [SIZE_W-1:0] sizeReg;
  burstKind_e        kindReg;
  logic [ADDR_W-1:0] step;
  logic [ADDR_W-1:0] span;
  logic [ADDR_W-1:0] stepped;

  assign step    = ADDR_W'(1) << sizeReg;
  assign span    = ADDR_W'(burstLen) << sizeReg;
  assign stepped = offset + step;
  assign outAddr = startAddr + offset;

  always_ff @(posedge clk) begin
    if (rst) begin
      startAddr <= '0;
      offset    <= '0;
      sizeReg   <= '0;
      burstLen  <= '0;
      kindReg   <= KIND_FIXED;
    end else if (strobe.capture) begin
      startAddr <= inAddr;
      offset    <= '0;
      sizeReg   <= inSize;
      burstLen  <= inLen;
      kindReg   <= burstKind_e'(inKind);
    end else if (strobe.advance) begin
      unique case (kindReg)
        KIND_INCR: offset <= stepped;
        KIND_WRAP: offset <= (stepped == span) ? '0 : stepped;
        default:   offset <= offset;
      endcase
    end
  end

endmodule

// File: rtl/burst_beat_expander.sv
module burst_beat_expander
  import burst_beat_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 8,
  parameter int SIZE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  output logic              inReady,
  input  logic [ADDR_W-1:0] inAddr,
  input  logic [1:0]        inKind,
  input  logic [LEN_W-1:0]  inLen,
  input  logic [SIZE_W-1:0] inSize,
  output logic              outValid,
  input  logic              outReady,
  output logic [ADDR_W-1:0] outAddr
);

  beatStrobe_t      strobe;
  logic [LEN_W-1:0] burstLen;

  burst_beat_ctrl #(.LEN_W(LEN_W)) ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .inReady  (inReady),
    .outReady (outReady),
    .outValid (outValid),
    .burstLen (burstLen),
    .strobe   (strobe)
  );

  burst_beat_addr #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .SIZE_W(SIZE_W)) datapath (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .inAddr   (inAddr),
    .inKind   (inKind),
    .inLen    (inLen),
    .inSize   (inSize),
    .burstLen (burstLen),
    .outAddr  (outAddr)
  );

endmodule

// File: rtl/burst_beat_expander_checker.sv
module burst_beat_expander_checker #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 8,
  parameter int SIZE_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              inValid,
  input logic              inReady,
  input logic [ADDR_W-1:0] inAddr,
  input logic [1:0]        inKind,
  input logic [LEN_W-1:0]  inLen,
  input logic [SIZE_W-1:0] inSize,
  input logic              outValid,
  input logic              outReady,
  input logic [ADDR_W-1:0] outAddr
);

  logic [LEN_W-1:0]  lenSnap;
  logic [LEN_W-1:0]  beatsSeen;
  logic [1:0]        kindSnap;
  logic [ADDR_W-1:0] addrSnap;

  always_ff @(posedge clk) begin
    if (rst) begin
      lenSnap   <= '0;
      beatsSeen <= '0;
      kindSnap  <= 2'b00;
      addrSnap  <= '0;
    end else if (inValid && inReady) begin
      lenSnap   <= inLen;
      beatsSeen <= '0;
      kindSnap  <= inKind;
      addrSnap  <= inAddr;
    end else if (outValid && outReady) begin
      beatsSeen <= beatsSeen + 1'b1;
    end
  end

  // R1: the beat that frees the input is the (L+1)-th beat
  assert_final_count_R1: assert property (@(posedge clk) disable iff (rst)
    (outValid && outReady && inReady) |-> (beatsSeen == lenSnap));

  // R1: a beat that does not free the input is not the last one
  assert_early_count_R1: assert property (@(posedge clk) disable iff (rst)
    (outValid && outReady && !inReady) |-> (beatsSeen < lenSnap));

  // R2: fixed bursts repeat the captured address
  assert_fixed_addr_R2: assert property (@(posedge clk) disable iff (rst)
    (outValid && (kindSnap == 2'b00 || kindSnap == 2'b11)) |-> (outAddr == addrSnap));

  // R5: a stalled beat keeps the input closed
  assert_hold_input_R5: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady) |-> !inReady);

  // R5: an idle block is open for a command
  assert_idle_open_R5: assert property (@(posedge clk) disable iff (rst)
    !outValid |-> inReady);

  // R6: stalled beat stays valid and stable
  assert_stall_stable_R6: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady) |=> (outValid && $stable(outAddr)));

  // R8: reset clears the output stream
  assert_reset_idle_R8: assert property (@(posedge clk)
    rst |=> (!outValid && inReady));

  // R9: a captured command is on the output in the next cycle
  assert_no_bubble_R9: assert property (@(posedge clk) disable iff (rst)
    (inValid && inReady) |=> outValid);

endmodule

bind burst_beat_expander burst_beat_expander_checker #(
  .ADDR_W(ADDR_W), .LEN_W(LEN_W), .SIZE_W(SIZE_W)
) chk (
  .clk      (clk),
  .rst      (rst),
  .inValid  (inValid),
  .inReady  (inReady),
  .inAddr   (inAddr),
  .inKind   (inKind),
  .inLen    (inLen),
  .inSize   (inSize),
  .outValid (outValid),
  .outReady (outReady),
  .outAddr  (outAddr)
);

// File: tb/burst_beat_expander_test.sv
module burst_beat_expander_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [31:0] inAddr = '0;
  logic [1:0]  inKind = 2'b00;
  logic [7:0]  inLen = '0;
  logic [2:0]  inSize = '0;
  logic        outValid;
  logic        outReady;
  logic [31:0] outAddr;

  int total = 0;
  int fails = 0;
  int cyc = 0;
  int sinkMode = 0;      // 0 always ready, 1 random, 2 never
  int fires = 0;
  int firstFire = -1;
  int lastFire = -1;
  logic [31:0] expQ[$];
  string       tagQ[$];

  always #10 clk = ~clk;  // 50 MHz
  always @(posedge clk) cyc <= cyc + 1;

  burst_beat_expander uut (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady),
    .inAddr(inAddr), .inKind(inKind), .inLen(inLen), .inSize(inSize),
    .outValid(outValid), .outReady(outReady), .outAddr(outAddr)
  );

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model(logic [31:0] a, logic [1:0] k,
                                        logic [7:0] l, logic [2:0] s, int i);
    logic [31:0] off;
    off = 32'(i) << s;
    case (k)
      2'b01:   return a + off;
      2'b10:   return (l == 0) ? a : a + (off % (32'(l) << s));
      default: return a;
    endcase
  endfunction

  // Sink: picks outReady at each falling edge, records the beat taken at the next rise
  initial begin
    outReady = 1'b0;
    forever begin
      @(negedge clk);
      case (sinkMode)
        0:       outReady = 1'b1;
        1:       outReady = ($urandom % 2) == 1;
        default: outReady = 1'b0;
      endcase
      #1;
      if (outValid && outReady) begin
        fires++;
        if (firstFire < 0) firstFire = cyc;
        lastFire = cyc;
        if (expQ.size() == 0) begin
          check(1'b0, "R1 unexpected beat", outAddr, 32'h0);
        end else begin
          logic [31:0] e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          check(outAddr == e, t, outAddr, e);
        end
      end
    end
  end

  task automatic sendCmd(logic [31:0] a, logic [1:0] k, logic [7:0] l,
                         logic [2:0] s, string tag);
    @(negedge clk);
    inValid = 1'b1; inAddr = a; inKind = k; inLen = l; inSize = s;
    #2;
    while (!inReady) begin
      @(negedge clk);
      #2;
    end
    for (int i = 0; i <= int'(l); i++) begin
      expQ.push_back(model(a, k, l, s, i));
      tagQ.push_back(tag);
    end
    @(posedge clk);
  endtask

  task automatic drain(string tag);
    @(negedge clk);
    inValid = 1'b0;
    while (expQ.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    #2;
    check(outValid == 1'b0, {tag, " no extra beat"}, 32'(outValid), 32'h0);
  endtask

  task automatic testReset();
    @(negedge clk);
    #2;
    check(outValid == 1'b0, "R8 outValid after reset", 32'(outValid), 32'h0);
    check(inReady == 1'b1, "R8 inReady after reset", 32'(inReady), 32'h1);
  endtask

  task automatic testFixed();
    sinkMode = 1;
    sendCmd(32'h0000_1230, 2'b00, 8'd5, 3'd2, "R2 fixed");
    drain("R1 fixed");
    sendCmd(32'h0000_4440, 2'b11, 8'd3, 3'd2, "R2 kind 11");
    drain("R1 kind 11");
  endtask

  task automatic testIncr();
    sinkMode = 1;
    sendCmd(32'h0000_1000, 2'b01, 8'd7, 3'd2, "R3 incr");
    drain("R1 incr");
    sendCmd(32'hFFFF_FFF8, 2'b01, 8'd3, 3'd2, "R3 incr top crossing");
    drain("R1 incr top");
    sendCmd(32'h0000_0010, 2'b01, 8'd4, 3'd0, "R3 incr byte");
    drain("R1 incr byte");
  endtask

  task automatic testWrap();
    sinkMode = 1;
    sendCmd(32'h0000_0004, 2'b10, 8'd3, 3'd1, "R4 wrap 4/3/1");
    drain("R1 wrap 4/3/1");
    sendCmd(32'h0000_0100, 2'b10, 8'd4, 3'd2, "R4 wrap 100/4/2");
    drain("R1 wrap 100/4/2");
    sendCmd(32'h0000_0ABC, 2'b10, 8'd0, 3'd2, "R4 wrap len0");
    drain("R1 wrap len0");
  endtask

  task automatic testStall();
    sinkMode = 2;
    sendCmd(32'h0000_0200, 2'b01, 8'd2, 3'd2, "R6 stalled burst");
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      inValid = 1'b1; inAddr = 32'h0000_0300; inKind = 2'b00; inLen = 8'd9;
      #2;
      check(inReady == 1'b0, "R5 inReady while stalled", 32'(inReady), 32'h0);
      check(outValid == 1'b1, "R6 outValid held", 32'(outValid), 32'h1);
      check(outAddr == 32'h0000_0200, "R6 outAddr held", outAddr, 32'h0000_0200);
    end
    @(negedge clk);
    inValid = 1'b0;
    sinkMode = 0;
    drain("R5 stalled burst");
  endtask

  task automatic testCapture();
    sinkMode = 1;
    sendCmd(32'h0000_8000, 2'b01, 8'd6, 3'd3, "R7 captured params");
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      inValid = 1'b0;
      inAddr = $urandom; inKind = 2'b10; inLen = 8'd1; inSize = 3'd0;
    end
    drain("R7 captured params");
  endtask

  task automatic testBackToBack();
    sinkMode = 0;
    fires = 0; firstFire = -1; lastFire = -1;
    sendCmd(32'h0000_2000, 2'b01, 8'd3, 3'd2, "R9 first burst");
    sendCmd(32'h0000_3000, 2'b00, 8'd2, 3'd2, "R9 second burst");
    drain("R9 back to back");
    check(fires == 7, "R9 beat total", 32'(fires), 32'd7);
    check(lastFire - firstFire + 1 == 7, "R9 unbroken run",
          32'(lastFire - firstFire + 1), 32'd7);
  endtask

  task automatic testRandom();
    sinkMode = 1;
    for (int n = 0; n < 60; n++) begin
      logic [1:0] k;
      logic [7:0] l;
      k = 2'($urandom % 4);
      l = (n % 10 == 0) ? 8'($urandom % 255) : 8'($urandom % 24);
      sendCmd($urandom, k, l, 3'($urandom % 4), "R1 random traffic");
      if ($urandom % 3 == 0) begin
        @(negedge clk);
        inValid = 1'b0;
        repeat ($urandom % 4) @(negedge clk);
      end
    end
    drain("R1 random traffic");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    total++;
    $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    void'($urandom(7));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    testReset();
    testFixed();
    testIncr();
    testWrap();
    testStall();
    testCapture();
    testBackToBack();
    testRandom();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule